// File: doc/BRIEF.md
# Clock-Multiplier Setup and Restart Sequencer

This block holds an 8-bit setup register that chooses the core clock multiplier. It also decides when the protocol core may run after a rate change. A host writes the setup register or a command register through one write port, and it can read the setup register back at any time. Writing a new multiplier code halts the core and enables the PLL. A cycle counter stands in for PLL settling. The core restarts only after a restart command (byte 0x18) and only after the lock flag is up. A restart command that arrives early is held pending until lock. The multiplier may be changed once per hardware reset. A second change, or a write of the reserved code, is refused and raises a sticky error flag.

The sequencer has four states:
- `ST_RUN`: the core runs. This is the reset state.
- `ST_WAIT_LOCK`: the core is halted and the PLL is settling.
- `ST_LOCK_HALT`: the PLL is locked and the block waits for the restart command.
- `ST_PEND`: a restart command came before lock and waits for lock.

The transitions are:
- *change-accept*: `ST_RUN`→`ST_WAIT_LOCK`.
- *early-restart*: `ST_WAIT_LOCK`→`ST_PEND`.
- *lock-reached*: `ST_WAIT_LOCK`→`ST_LOCK_HALT`.
- *lock-and-restart* (both in the same cycle): `ST_WAIT_LOCK`→`ST_RUN`.
- *pending-release*: `ST_PEND`→`ST_RUN`.
- *restart*: `ST_LOCK_HALT`→`ST_RUN`.

Top module: `clkmul_setup_seq`

## Requirements
- R1: After reset, all of these hold: `setup_rd` reads 0x00, `core_run`=1, `pll_en`=0, `mul_sel`=00, `pll_locked`=0, `enh_en`=0, `nosync`=0, and all three error flags are 0.
- R2: `wr_sel`=0 selects the setup register and `wr_sel`=1 selects the command register. The setup register fields are:
  - bit 7: fast-read enable.
  - bit 6: reserved. A write to it is ignored and it reads 0.
  - bits 5:4: multiplier code. 00 is 20 MHz, 01 is 40 MHz, 10 is reserved, 11 is 80 MHz.
  - bit 3: enhanced-functions enable.
  - bit 2: no-sync.
  - bits 1:0: read 0.

  Every setup write updates bits 7, 3 and 2.
- R3: A setup write whose code differs from the held code is accepted if it is the first change since reset and the code is not 10. On the next cycle `core_run`=0, `pll_en`=1 and `mul_sel` shows the new code.
- R4: `pll_locked` rises exactly `LOCK_CYCLES` clock edges after the edge that accepted the change. It stays high until reset.
- R5: Restart rules:
  - A command write of 0x18 while halted and locked sets `core_run`=1 on the next cycle.
  - A 0x18 written before lock is held, and `core_run` rises one cycle after `pll_locked` rises.
  - Any other command byte does nothing.
  - A 0x18 written while running does nothing.
- R6: After the first accepted change, a setup write with a different, non-reserved code leaves `mul_sel` unchanged and sets `err_repeat`.
- R7: A setup write with code 10 and a different held code leaves `mul_sel` unchanged and sets `err_reserved`. The other fields of that write are still stored.
- R8: `err_rate` is set when the core is restarted while code 11 is held and the enhanced bit is 0.
- R9: `hs_read_en` is 1 only when `bus_timing_pin`, `bus_nonmux` and setup bit 7 are all 1.
- R10: The error flags are sticky and clear only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 0 selects the setup register, 1 selects the command register |
| wr_data | input | 8 | Host write data |
| bus_timing_pin | input | 1 | External bus-timing strap |
| bus_nonmux | input | 1 | 1 when the host bus is non-multiplexed |
| setup_rd | output | 8 | Setup register read value |
| pll_en | output | 1 | PLL enable |
| mul_sel | output | 2 | Multiplier select code |
| core_run | output | 1 | 1 lets the protocol core run, 0 halts it |
| pll_locked | output | 1 | Lock flag from the settling timer |
| hs_read_en | output | 1 | High-speed read timing enable |
| enh_en | output | 1 | Enhanced-functions enable |
| nosync | output | 1 | No-sync option |
| err_repeat | output | 1 | A second multiplier change was refused |
| err_reserved | output | 1 | The reserved code was refused |
| err_rate | output | 1 | Restart at 80 MHz with the enhanced bit clear |

## Verification
Some properties are checked on every cycle:
- An accepted change halts the core on the next cycle.
- The core never leaves halt without lock.
- The held code never becomes 10, and it stays frozen once the single change is used.
- The lock flag stays up once set.
- `err_rate` rises only with code 11 and the enhanced bit clear.

The bench scenarios show the rest:
- the exact lock latency;
- early versus late restart timing;
- that wrong command bytes do nothing;
- that reserved bit 6 is ignored;
- that the error flags persist until reset and clear at it.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;
    localparam int REG_W = 8;
    localparam logic [REG_W-1:0] RESTART_CMD = 8'h18;

    typedef enum logic [1:0] {
        MUL_20  = 2'b00,
        MUL_40  = 2'b01,
        MUL_RSV = 2'b10,
        MUL_80  = 2'b11
    } mul_code_t;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_WAIT_LOCK,
        ST_LOCK_HALT,
        ST_PEND
    } seq_state_t;
endpackage

// File: rtl/clkmul_setup_reg.sv
module clkmul_setup_reg
    import clkmul_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_stb,
    input  logic      wr_fast,
    input  logic [1:0] wr_mul,
    input  logic      wr_enh,
    input  logic      wr_nosync,
    output logic      fast_q,
    output mul_code_t mul_q,
    output logic      enh_q,
    output logic      nosync_q,
    output logic      change_acc,
    output logic      err_repeat_q,
    output logic      err_reserved_q
);
    mul_code_t new_mul;
    logic      differs;
    logic      rsv_hit;
    logic      rep_hit;
    logic      used_q;

    always_comb begin
        new_mul    = mul_code_t'(wr_mul);
        differs    = wr_stb && (new_mul != mul_q);
        rsv_hit    = differs && (new_mul == MUL_RSV);
        rep_hit    = differs && !rsv_hit && used_q;
        change_acc = differs && !rsv_hit && !used_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_q         <= 1'b0;
            mul_q          <= MUL_20;
            enh_q          <= 1'b0;
            nosync_q       <= 1'b0;
            used_q         <= 1'b0;
            err_repeat_q   <= 1'b0;
            err_reserved_q <= 1'b0;
        end else begin
            if (wr_stb) begin
                fast_q   <= wr_fast;
                enh_q    <= wr_enh;
                nosync_q <= wr_nosync;
            end
            if (change_acc) begin
                mul_q  <= new_mul;
                used_q <= 1'b1;
            end
            if (rep_hit) err_repeat_q <= 1'b1;
            if (rsv_hit) err_reserved_q <= 1'b1;
        end
    end

    // R6: once the single change is used, the code never moves
    a_r6_mul_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        used_q |=> $stable(mul_q));
    // R7: the reserved code is never held
    a_r7_no_rsv_held: assert property (@(posedge clk) disable iff (!rst_n)
        mul_q != MUL_RSV);
    // R7: a refused reserved write leaves the code untouched
    a_r7_rsv_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_hit |=> $stable(mul_q));
endmodule

// File: rtl/clkmul_lock_timer.sv
module clkmul_lock_timer #(
    parameter int LOCK_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic locked_q
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             running_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
            locked_q  <= 1'b0;
        end else if (start) begin
            cnt_q     <= '0;
            running_q <= 1'b1;
        end else if (running_q) begin
            if (cnt_q == LAST) begin
                running_q <= 1'b0;
                locked_q  <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R4: lock is sticky until reset
    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> locked_q);
    // R4: lock is never reported in the cycle after a start
    a_r4_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !locked_q);
endmodule

// File: rtl/clkmul_seq_fsm.sv
module clkmul_seq_fsm
    import clkmul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic change_acc,
    input  logic restart_cmd,
    input  logic locked,
    input  logic rate80,
    input  logic enh,
    output logic core_run,
    output logic err_rate_q
);
    seq_state_t state_q;
    seq_state_t state_d;
    logic       restart_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:       if (change_acc) state_d = ST_WAIT_LOCK;
            ST_WAIT_LOCK: begin
                if (locked && restart_cmd) state_d = ST_RUN;
                else if (locked)           state_d = ST_LOCK_HALT;
                else if (restart_cmd)      state_d = ST_PEND;
            end
            ST_LOCK_HALT: if (restart_cmd) state_d = ST_RUN;
            ST_PEND:      if (locked) state_d = ST_RUN;
            default:      state_d = ST_RUN;
        endcase
    end

    always_comb begin
        core_run   = (state_q == ST_RUN);
        restart_go = (state_q != ST_RUN) && (state_d == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             err_rate_q <= 1'b0;
        else if (restart_go && rate80 && !enh)  err_rate_q <= 1'b1;
    end

    // R3: an accepted change halts the core on the next cycle
    a_r3_halt_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        change_acc |=> !core_run);
    // R5: the core never resumes without lock
    a_r5_run_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_run) |-> locked);
    // R10: the rate error is sticky
    a_r10_rate_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_rate_q |=> err_rate_q);
endmodule

// File: rtl/clkmul_setup_seq.sv
module clkmul_setup_seq
    import clkmul_pkg::*;
#(
    parameter int LOCK_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       bus_timing_pin,
    input  logic       bus_nonmux,
    output logic [7:0] setup_rd,
    output logic       pll_en,
    output logic [1:0] mul_sel,
    output logic       core_run,
    output logic       pll_locked,
    output logic       hs_read_en,
    output logic       enh_en,
    output logic       nosync,
    output logic       err_repeat,
    output logic       err_reserved,
    output logic       err_rate
);
    logic      setup_wr;
    logic      restart_cmd;
    logic      fast_q;
    mul_code_t mul_q;
    logic      change_acc;

    always_comb begin
        setup_wr    = wr_en && !wr_sel;
        restart_cmd = wr_en && wr_sel && (wr_data == RESTART_CMD);
    end

    clkmul_setup_reg u_reg (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_stb         (setup_wr),
        .wr_fast        (wr_data[7]),
        .wr_mul         (wr_data[5:4]),
        .wr_enh         (wr_data[3]),
        .wr_nosync      (wr_data[2]),
        .fast_q         (fast_q),
        .mul_q          (mul_q),
        .enh_q          (enh_en),
        .nosync_q       (nosync),
        .change_acc     (change_acc),
        .err_repeat_q   (err_repeat),
        .err_reserved_q (err_reserved)
    );

    clkmul_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (change_acc),
        .locked_q (pll_locked)
    );

    clkmul_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .change_acc  (change_acc),
        .restart_cmd (restart_cmd),
        .locked      (pll_locked),
        .rate80      (mul_q == MUL_80),
        .enh         (enh_en),
        .core_run    (core_run),
        .err_rate_q  (err_rate)
    );

    always_comb begin
        mul_sel    = mul_q;
        pll_en     = (mul_q != MUL_20);
        hs_read_en = bus_timing_pin && bus_nonmux && fast_q;
        setup_rd   = {fast_q, 1'b0, mul_q, enh_en, nosync, 2'b00};
    end

    // R8: the rate error only rises with code 11 and the enhanced bit clear
    a_r8_rate_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_rate) |-> (mul_sel == 2'b11) && !enh_en);
    // R3: whenever the core is halted, the PLL is enabled
    a_r3_halt_has_pll: assert property (@(posedge clk) disable iff (!rst_n)
        !core_run |-> pll_en);
endmodule

// File: tb/clkmul_setup_seq_tb_top.sv
module clkmul_setup_seq_tb_top;
    localparam int LOCK = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       bus_timing_pin = 1'b0;
    logic       bus_nonmux = 1'b0;
    logic [7:0] setup_rd;
    logic       pll_en, core_run, pll_locked, hs_read_en, enh_en, nosync;
    logic [1:0] mul_sel;
    logic       err_repeat, err_reserved, err_rate;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    clkmul_setup_seq #(.LOCK_CYCLES(LOCK)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .bus_timing_pin(bus_timing_pin), .bus_nonmux(bus_nonmux),
        .setup_rd(setup_rd), .pll_en(pll_en), .mul_sel(mul_sel), .core_run(core_run),
        .pll_locked(pll_locked), .hs_read_en(hs_read_en), .enh_en(enh_en), .nosync(nosync),
        .err_repeat(err_repeat), .err_reserved(err_reserved), .err_rate(err_rate)
    );

    // {pin, nonmux, bit7, expected hs_read_en}
    localparam logic [3:0] HS_VEC [8] = '{
        4'b0000, 4'b0010, 4'b0100, 4'b0110,
        4'b1000, 4'b1010, 4'b1100, 4'b1111
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 setup_rd", setup_rd, 8'h00);
        check("R1 core_run", {7'd0, core_run}, 8'd1);
        check("R1 pll_en", {7'd0, pll_en}, 8'd0);
        check("R1 mul_sel", {6'd0, mul_sel}, 8'd0);
        check("R1 locked", {7'd0, pll_locked}, 8'd0);
        check("R1 errors", {5'd0, err_repeat, err_reserved, err_rate}, 8'd0);
        check("R1 enh/nosync", {6'd0, enh_en, nosync}, 8'd0);

        // R9 vector table
        for (int i = 0; i < 8; i++) begin
            bus_timing_pin = HS_VEC[i][3];
            bus_nonmux     = HS_VEC[i][2];
            wr(1'b0, {HS_VEC[i][1], 7'b0});
            check($sformatf("R9 vec%0d", i), {7'd0, hs_read_en}, {7'd0, HS_VEC[i][0]});
        end
        bus_timing_pin = 1'b0; bus_nonmux = 1'b0;

        // R2 field layout, reserved bit 6 ignored
        wr(1'b0, 8'hC7);
        check("R2 readback", setup_rd, 8'h84);
        check("R2 nosync", {7'd0, nosync}, 8'd1);

        // R7 reserved code refused, other fields stored
        wr(1'b0, 8'h28);
        check("R7 mul kept", {6'd0, mul_sel}, 8'd0);
        check("R7 err_reserved", {7'd0, err_reserved}, 8'd1);
        check("R7 enh stored", {7'd0, enh_en}, 8'd1);
        check("R7 still running", {7'd0, core_run}, 8'd1);

        // R5 restart command while running has no effect
        wr(1'b1, 8'h18);
        check("R5 run unaffected", {7'd0, core_run}, 8'd1);
        check("R5 pll still off", {7'd0, pll_en}, 8'd0);

        // R3 accepted change to 80 MHz, enhanced bit clear
        wr(1'b0, 8'h30);
        check("R3 halted", {7'd0, core_run}, 8'd0);
        check("R3 pll_en", {7'd0, pll_en}, 8'd1);
        check("R3 mul_sel", {6'd0, mul_sel}, 8'd3);
        // R4 exact lock latency
        repeat (LOCK - 1) @(negedge clk);
        check("R4 not yet locked", {7'd0, pll_locked}, 8'd0);
        @(negedge clk);
        check("R4 locked", {7'd0, pll_locked}, 8'd1);

        // R5 wrong command byte does nothing
        wr(1'b1, 8'h17);
        check("R5 wrong cmd", {7'd0, core_run}, 8'd0);
        // R5 restart after lock, R8 rate error
        wr(1'b1, 8'h18);
        check("R5 restarted", {7'd0, core_run}, 8'd1);
        check("R8 err_rate", {7'd0, err_rate}, 8'd1);

        // R6 second change refused
        wr(1'b0, 8'h10);
        check("R6 mul kept", {6'd0, mul_sel}, 8'd3);
        check("R6 err_repeat", {7'd0, err_repeat}, 8'd1);
        check("R6 still running", {7'd0, core_run}, 8'd1);

        // R10 sticky, then cleared by reset
        repeat (10) @(negedge clk);
        check("R10 sticky", {5'd0, err_repeat, err_reserved, err_rate}, 8'h07);
        check("R4 lock held", {7'd0, pll_locked}, 8'd1);
        do_reset();
        check("R10 cleared", {5'd0, err_repeat, err_reserved, err_rate}, 8'h00);

        // R5 early restart held pending; R8 no error at 40 MHz
        wr(1'b0, 8'h18);
        wr(1'b1, 8'h18);
        check("R5 pending halted", {7'd0, core_run}, 8'd0);
        for (int k = 0; k < 100 && !pll_locked; k++) @(negedge clk);
        check("R5 locked seen", {7'd0, pll_locked}, 8'd1);
        check("R5 not yet run", {7'd0, core_run}, 8'd0);
        @(negedge clk);
        check("R5 released", {7'd0, core_run}, 8'd1);
        check("R8 no err at 40", {7'd0, err_rate}, 8'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule